// File: doc/BRIEF.md
# Level-Triggered Interrupt and Timer Controller

This block is the master interrupt controller of a small processor system. It watches eight external bus interrupt lines and a keyboard request, and it runs two periodic timers of its own: a frame timer and a faster sample timer. It drives two processor priority-level request outputs. The level-2 output carries the frame timer, the keyboard and the external lines. The level-4 output carries the sample timer.

Software works through a small register window. Two registers are read-only status views. The internal view summarises the frame, keyboard, serial, external and sample sources. The external view shows the present level of each bus line and holds nothing. The remaining addresses are write-only controls: a single enable for the upper external lines, a keyboard enable, rate selects for both timers, and clear strobes for both timer requests.

The frame request cannot be masked. It stays set until software acknowledges it by writing all-ones. A timer rate change is applied when the running period ends, so no short or long tick is produced.

Top module: `irq_master_ctl`

## Requirements
- R1: After reset both level outputs are low, the low nibble of the internal status (address 0) reads 0, and the external enable, keyboard enable and both rate selects are 0.
- R2: Address 1 returns the live level of the external lines. Bit 0..7 correspond to bus lines 3, 4, 5, 6, 7, 10, 14 and 15. The value is not latched and does not depend on any enable.
- R3: Writing bit 0 of address 2 sets the external enable. While it is 0, bus lines 5 to 15 (status bits 2..7) do not set the external summary bit (bit 3 of address 0) and do not raise level 2. While it is 1, they do both. Lines 3 and 4 (bits 0..1) always set the serial bit (bit 2 of address 0) and raise level 2.
- R4: Bit 0 of address 3 enables the keyboard request. While it is 1, a keyboard request sets bit 1 of address 0 and raises level 2. While it is 0, the request is invisible at both places.
- R5: The frame period is CLK_HZ/50 cycles when bit 0 of address 4 is 0, and CLK_HZ/200 cycles when it is 1. Each period end sets the frame-pending bit (bit 0 of address 0).
- R6: A pending frame request raises level 2 whatever the two enables hold.
- R7: Only a write of 0xFF to address 5 clears the frame-pending bit. Any other value written there leaves it set.
- R8: A rate change written during a period takes effect only after that period has completed at its old length.
- R9: The sample period is CLK_HZ/10000 cycles when bit 0 of address 6 is 0, and CLK_HZ/20000 cycles when it is 1. Each period end sets the sample-pending bit (bit 4 of address 0), which drives level 4.
- R10: Any write to address 7 clears the sample-pending bit and drops level 4 on the next cycle, unless a sample period ends in that same cycle.
- R11: The level-2 output follows the external lines, the keyboard request and the enables in the same cycle, with no register between them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr_i | input | 3 | Register address |
| bus_wr_i | input | 1 | Write strobe, one cycle per write |
| bus_wdata_i | input | 8 | Write data |
| bus_rdata_o | output | 8 | Read data for the addressed status register, 0 elsewhere |
| ext_irq_i | input | 8 | External bus interrupt lines, level sensitive, active high |
| kbd_irq_i | input | 1 | Keyboard interrupt request, level sensitive |
| ipl2_o | output | 1 | Priority level 2 request |
| ipl4_o | output | 1 | Priority level 4 request |

## Verification
A wrong divider count shows as a wrong distance between two rising edges of the frame or sample pending bit. It appears within one period, and a stale rate select shows up one period later. A pending flag stuck high or low is visible on the next cycle after a clear write, or at the next period end. A wrong enable or gating term changes level 2 and the status word combinationally, in the same cycle as the input change.

// File: rtl/irq_master_ctl_pkg.sv
package irq_master_ctl_pkg;

  localparam int DATA_W    = 8;
  localparam int ADDR_W    = 3;
  localparam int NUM_EXT   = 8;
  localparam int NUM_ALWAYS = 2;  // lines that bypass the external enable

  // register window
  localparam logic [ADDR_W-1:0] ADR_INT_STAT   = 3'd0;
  localparam logic [ADDR_W-1:0] ADR_EXT_STAT   = 3'd1;
  localparam logic [ADDR_W-1:0] ADR_EXT_EN     = 3'd2;
  localparam logic [ADDR_W-1:0] ADR_KBD_EN     = 3'd3;
  localparam logic [ADDR_W-1:0] ADR_FRAME_RATE = 3'd4;
  localparam logic [ADDR_W-1:0] ADR_FRAME_ACK  = 3'd5;
  localparam logic [ADDR_W-1:0] ADR_SAMP_RATE  = 3'd6;
  localparam logic [ADDR_W-1:0] ADR_SAMP_ACK   = 3'd7;

  localparam logic [DATA_W-1:0] FRAME_ACK_KEY = 8'hFF;

  // internal status bit positions
  localparam int ST_FRAME = 0;
  localparam int ST_KBD   = 1;
  localparam int ST_SER   = 2;
  localparam int ST_EXT   = 3;
  localparam int ST_SAMP  = 4;

  // cycles per timer period
  function automatic int unsigned period_cycles(int unsigned clk_hz, int unsigned rate_hz);
    return clk_hz / rate_hz;
  endfunction

  // mask applied to the external lines for a given enable
  function automatic logic [NUM_EXT-1:0] ext_gate_mask(logic en);
    return {{(NUM_EXT-NUM_ALWAYS){en}}, {NUM_ALWAYS{1'b1}}};
  endfunction

  function automatic logic [DATA_W-1:0] pack_int_status(logic frame, logic kbd,
                                                        logic ser, logic ext, logic samp);
    logic [DATA_W-1:0] w;
    w           = '0;
    w[ST_FRAME] = frame;
    w[ST_KBD]   = kbd;
    w[ST_SER]   = ser;
    w[ST_EXT]   = ext;
    w[ST_SAMP]  = samp;
    return w;
  endfunction

endpackage

// File: rtl/irq_master_ctl_divider.sv
module irq_master_ctl_divider #(
  parameter int unsigned SLOW_DIV = 800000,
  parameter int unsigned FAST_DIV = 200000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic fast_sel_i,
  output logic tick_o
);

  localparam int unsigned MAX_DIV = (SLOW_DIV > FAST_DIV) ? SLOW_DIV : FAST_DIV;
  localparam int CW = $clog2(MAX_DIV + 1);
  localparam logic [CW-1:0] SLOW_LOAD = CW'(SLOW_DIV - 1);
  localparam logic [CW-1:0] FAST_LOAD = CW'(FAST_DIV - 1);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] reload;

  // the rate select is sampled only at the period boundary
  assign reload = fast_sel_i ? FAST_LOAD : SLOW_LOAD;
  assign tick_o = (cnt_q == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= SLOW_LOAD;
    else if (tick_o) cnt_q <= reload;
    else             cnt_q <= cnt_q - 1'b1;
  end

  // R8
  period_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tick_o |=> (cnt_q == SLOW_LOAD) || (cnt_q == FAST_LOAD));

endmodule

// File: rtl/irq_master_ctl_regs.sv
module irq_master_ctl_regs
  import irq_master_ctl_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              frame_tick_i,
  input  logic              samp_tick_i,
  output logic              ext_en_o,
  output logic              kbd_en_o,
  output logic              frame_fast_o,
  output logic              samp_fast_o,
  output logic              frame_pend_o,
  output logic              samp_pend_o
);

  logic frame_ack_hit;
  logic samp_ack_hit;

  assign frame_ack_hit = wr_i && (addr_i == ADR_FRAME_ACK) && (wdata_i == FRAME_ACK_KEY);
  assign samp_ack_hit  = wr_i && (addr_i == ADR_SAMP_ACK);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ext_en_o     <= 1'b0;
      kbd_en_o     <= 1'b0;
      frame_fast_o <= 1'b0;
      samp_fast_o  <= 1'b0;
    end else if (wr_i) begin
      case (addr_i)
        ADR_EXT_EN:     ext_en_o     <= wdata_i[0];
        ADR_KBD_EN:     kbd_en_o     <= wdata_i[0];
        ADR_FRAME_RATE: frame_fast_o <= wdata_i[0];
        ADR_SAMP_RATE:  samp_fast_o  <= wdata_i[0];
        default: ;
      endcase
    end
  end

  // a period end in the same cycle as a clear keeps the request
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      frame_pend_o <= 1'b0;
      samp_pend_o  <= 1'b0;
    end else begin
      frame_pend_o <= frame_tick_i | (frame_pend_o & ~frame_ack_hit);
      samp_pend_o  <= samp_tick_i  | (samp_pend_o  & ~samp_ack_hit);
    end
  end

  // R7
  frame_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_pend_o && !frame_ack_hit) |=> frame_pend_o);

  // R7
  frame_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_ack_hit && !frame_tick_i) |=> !frame_pend_o);

  // R5
  frame_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_tick_i |=> frame_pend_o);

  // R10
  samp_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (samp_ack_hit && !samp_tick_i) |=> !samp_pend_o);

endmodule

// File: rtl/irq_master_ctl_status.sv
module irq_master_ctl_status
  import irq_master_ctl_pkg::*;
(
  input  logic [ADDR_W-1:0]  addr_i,
  input  logic [NUM_EXT-1:0] ext_lines_i,
  input  logic               kbd_req_i,
  input  logic               ext_en_i,
  input  logic               kbd_en_i,
  input  logic               frame_pend_i,
  input  logic               samp_pend_i,
  output logic [DATA_W-1:0]  rdata_o,
  output logic               ipl2_o,
  output logic               ipl4_o
);

  logic [NUM_EXT-1:0] ext_gated;
  logic               ser_act;
  logic               ext_act;
  logic               kbd_act;

  assign ext_gated = ext_lines_i & ext_gate_mask(ext_en_i);
  assign ser_act   = |ext_gated[NUM_ALWAYS-1:0];
  assign ext_act   = |ext_gated[NUM_EXT-1:NUM_ALWAYS];
  assign kbd_act   = kbd_req_i & kbd_en_i;

  assign ipl2_o = frame_pend_i | kbd_act | ser_act | ext_act;
  assign ipl4_o = samp_pend_i;

  always_comb begin
    case (addr_i)
      ADR_INT_STAT: rdata_o = pack_int_status(frame_pend_i, kbd_act, ser_act, ext_act, samp_pend_i);
      ADR_EXT_STAT: rdata_o = ext_lines_i;
      default:      rdata_o = '0;
    endcase
  end

endmodule

// File: rtl/irq_master_ctl.sv
module irq_master_ctl
  import irq_master_ctl_pkg::*;
#(
  parameter int unsigned CLK_HZ        = 40000000,
  parameter int unsigned FRAME_SLOW_HZ = 50,
  parameter int unsigned FRAME_FAST_HZ = 200,
  parameter int unsigned SAMP_SLOW_HZ  = 10000,
  parameter int unsigned SAMP_FAST_HZ  = 20000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [2:0] bus_addr_i,
  input  logic       bus_wr_i,
  input  logic [7:0] bus_wdata_i,
  output logic [7:0] bus_rdata_o,
  input  logic [7:0] ext_irq_i,
  input  logic       kbd_irq_i,
  output logic       ipl2_o,
  output logic       ipl4_o
);

  localparam int unsigned FRAME_SLOW_DIV = period_cycles(CLK_HZ, FRAME_SLOW_HZ);
  localparam int unsigned FRAME_FAST_DIV = period_cycles(CLK_HZ, FRAME_FAST_HZ);
  localparam int unsigned SAMP_SLOW_DIV  = period_cycles(CLK_HZ, SAMP_SLOW_HZ);
  localparam int unsigned SAMP_FAST_DIV  = period_cycles(CLK_HZ, SAMP_FAST_HZ);

  logic frame_tick, samp_tick;
  logic ext_en, kbd_en, frame_fast, samp_fast;
  logic frame_pend, samp_pend;

  irq_master_ctl_divider #(
    .SLOW_DIV (FRAME_SLOW_DIV),
    .FAST_DIV (FRAME_FAST_DIV)
  ) frame_div_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .fast_sel_i (frame_fast),
    .tick_o     (frame_tick)
  );

  irq_master_ctl_divider #(
    .SLOW_DIV (SAMP_SLOW_DIV),
    .FAST_DIV (SAMP_FAST_DIV)
  ) samp_div_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .fast_sel_i (samp_fast),
    .tick_o     (samp_tick)
  );

  irq_master_ctl_regs regs_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .wr_i         (bus_wr_i),
    .addr_i       (bus_addr_i),
    .wdata_i      (bus_wdata_i),
    .frame_tick_i (frame_tick),
    .samp_tick_i  (samp_tick),
    .ext_en_o     (ext_en),
    .kbd_en_o     (kbd_en),
    .frame_fast_o (frame_fast),
    .samp_fast_o  (samp_fast),
    .frame_pend_o (frame_pend),
    .samp_pend_o  (samp_pend)
  );

  irq_master_ctl_status status_i (
    .addr_i       (bus_addr_i),
    .ext_lines_i  (ext_irq_i),
    .kbd_req_i    (kbd_irq_i),
    .ext_en_i     (ext_en),
    .kbd_en_i     (kbd_en),
    .frame_pend_i (frame_pend),
    .samp_pend_i  (samp_pend),
    .rdata_o      (bus_rdata_o),
    .ipl2_o       (ipl2_o),
    .ipl4_o       (ipl4_o)
  );

  // R6
  frame_unmaskable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_pend |-> ipl2_o);

  // R3
  ext_masked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ext_en && ext_irq_i[1:0] == 2'b00 && !frame_pend && !(kbd_irq_i && kbd_en)) |-> !ipl2_o);

  // R2
  ext_live_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr_i == ADR_EXT_STAT) |-> (bus_rdata_o == ext_irq_i));

endmodule

// File: tb/irq_master_ctl_tb_top.sv
`timescale 1ns/1ps
module irq_master_ctl_tb_top;

  localparam int unsigned CLK_HZ     = 80000;
  localparam int          FRAME_SLOW = 1600;  // CLK_HZ / 50
  localparam int          FRAME_FAST = 400;   // CLK_HZ / 200
  localparam int          SAMP_SLOW  = 8;     // CLK_HZ / 10000
  localparam int          SAMP_FAST  = 4;     // CLK_HZ / 20000

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] addr = 3'd0;
  logic       wr = 1'b0;
  logic [7:0] wdata = 8'd0;
  logic [7:0] rdata;
  logic [7:0] ext = 8'd0;
  logic       kbd = 1'b0;
  logic       ipl2, ipl4;

  int cyc = 0;
  int errors = 0;
  int checks = 0;
  bit done = 1'b0;
  int exp_q[$];
  string tag_q[$];

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  irq_master_ctl #(.CLK_HZ(CLK_HZ)) dut_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .bus_addr_i  (addr),
    .bus_wr_i    (wr),
    .bus_wdata_i (wdata),
    .bus_rdata_o (rdata),
    .ext_irq_i   (ext),
    .kbd_irq_i   (kbd),
    .ipl2_o      (ipl2),
    .ipl4_o      (ipl4)
  );

  task automatic check(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // scoreboard: expectations are queued, measured results pop them
  task automatic push_exp(string tag, int val);
    tag_q.push_back(tag);
    exp_q.push_back(val);
  endtask

  task automatic sb_compare(int act);
    string t;
    int e;
    t = tag_q.pop_front();
    e = exp_q.pop_front();
    check(t, act, e);
  endtask

  // called at a negedge, returns at the next negedge with the write applied
  task automatic bus_write(logic [2:0] a, logic [7:0] d);
    addr = a; wdata = d; wr = 1'b1;
    @(negedge clk);
    wr = 1'b0; addr = 3'd0; wdata = 8'd0;
  endtask

  task automatic wait_frame(output int t);
    addr = 3'd0;
    #0.5;
    while (!rdata[0]) begin @(negedge clk); #0.5; end
    t = cyc;
  endtask

  task automatic wait_samp(output int t);
    #0.5;
    while (!ipl4) begin @(negedge clk); #0.5; end
    t = cyc;
  endtask

  task automatic samp_interval(output int iv, input bit chk_ack);
    int t0, t1;
    bus_write(3'd7, 8'h00);
    wait_samp(t0);
    @(negedge clk);
    bus_write(3'd7, 8'h5A);
    #0.5;
    // R10: the clear drops level 4 on the next cycle
    if (chk_ack) check("R10 ipl4 after clear", int'(ipl4), 0);
    wait_samp(t1);
    @(negedge clk);
    iv = t1 - t0;
  endtask

  task automatic int_stat(string tag, int exp_stat, int exp_ipl2);
    addr = 3'd0;
    #0.5;
    check({tag, " status"}, int'(rdata & 8'h0F), exp_stat);
    check({tag, " ipl2"}, int'(ipl2), exp_ipl2);
  endtask

  initial begin
    int iv, t0, t1, t2, t3;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    #0.5;
    check("R1 ipl2", int'(ipl2), 0);
    check("R1 ipl4", int'(ipl4), 0);
    check("R1 status", int'(rdata & 8'h0F), 0);

    // R2 live external view, independent of enable
    foreach (exp_q[i]) ;
    begin
      logic [7:0] pats [3] = '{8'hA5, 8'h3C, 8'hFF};
      foreach (pats[i]) begin
        ext = pats[i]; addr = 3'd1;
        #0.5;
        check("R2 ext view", int'(rdata), int'(pats[i]));
      end
    end
    @(negedge clk);
    ext = 8'h00; addr = 3'd0;

    // R3 upper lines gated by the enable, lower lines not
    ext = 8'h04;
    int_stat("R3 line5 masked", 0, 0);
    @(negedge clk);
    bus_write(3'd2, 8'h01);
    int_stat("R3 line5 enabled", 8, 1);
    ext = 8'h01;
    bus_write(3'd2, 8'h00);
    int_stat("R3 line3 ungated", 4, 1);
    ext = 8'h80;
    int_stat("R3 line15 masked", 0, 0);
    @(negedge clk);
    bus_write(3'd2, 8'h01);
    // R11 level 2 follows the line in the same cycle
    int_stat("R11 line15 enabled", 8, 1);
    ext = 8'h00;
    int_stat("R11 line15 drop", 0, 0);

    // R4 keyboard enable
    kbd = 1'b1;
    int_stat("R4 kbd masked", 0, 0);
    @(negedge clk);
    bus_write(3'd3, 8'h01);
    int_stat("R4 kbd enabled", 2, 1);
    @(negedge clk);
    bus_write(3'd3, 8'h00);
    int_stat("R4 kbd disabled", 0, 0);
    kbd = 1'b0;
    @(negedge clk);

    // R9 sample period, slow then fast
    samp_interval(iv, 1'b0);
    push_exp("R9 slow sample period", SAMP_SLOW);
    samp_interval(iv, 1'b1);
    sb_compare(iv);
    bus_write(3'd6, 8'h01);
    samp_interval(iv, 1'b0);
    push_exp("R9 fast sample period", SAMP_FAST);
    samp_interval(iv, 1'b1);
    sb_compare(iv);

    // frame timer, both enables off
    bus_write(3'd2, 8'h00);
    wait_frame(t0);
    // R6
    check("R6 frame raises ipl2", int'(ipl2), 1);
    @(negedge clk);
    bus_write(3'd5, 8'h7F);
    #0.5;
    check("R7 wrong key keeps pending", int'(rdata[0]), 1);
    bus_write(3'd5, 8'hFF);
    #0.5;
    check("R7 key clears pending", int'(rdata[0]), 0);
    check("R7 ipl2 after clear", int'(ipl2), 0);

    push_exp("R5 slow frame period", FRAME_SLOW);
    wait_frame(t1);
    sb_compare(t1 - t0);
    @(negedge clk);
    bus_write(3'd4, 8'h01);
    bus_write(3'd5, 8'hFF);
    push_exp("R8 period finishes at old rate", FRAME_SLOW);
    wait_frame(t2);
    sb_compare(t2 - t1);
    @(negedge clk);
    bus_write(3'd5, 8'hFF);
    push_exp("R5 fast frame period", FRAME_FAST);
    wait_frame(t3);
    sb_compare(t3 - t2);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule